// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming port of an eight-line priority interrupt controller. It has two addresses. Address 0 carries commands: the start of initialization, operation words that arm a poll or select the readback register, and end-of-interrupt and rotation commands. Address 1 carries data. Which data register a write lands in depends on how far the initialization sequence has got. Once that sequence is complete, data writes load the mask.

The block keeps the controller state that these commands change: the mask, the in-service register, the rotation base, the vector base and the mode flags. It exposes that state on ports so that a neighbouring arbiter can use it. The arbiter supplies the raw request vector and the current winning line as inputs. A read while a poll is armed returns that line and acknowledges it in the same way a hardware acknowledge would. Each command takes effect on the clock edge that ends its write cycle. Reads return data combinationally during the read cycle.

Top module: `icd_top`

## Requirements
- R1: A write to address 0 with bit 4 set moves the init step to 1. It clears the mask, in-service, rotation base, poll, read-select, special-mask, auto-EOI and rotate-on-auto-EOI state. It records bit 0 (fourth word wanted) and bit 1 (single mode). Reset leaves every output at zero.
- R2: In init step 1, a data write stores the vector base as the data byte with bits 2:0 cleared. The next step is 3 when both single mode and fourth-word are set, 0 when single mode is set without fourth-word, and 2 when single mode is clear.
- R3: In init step 2, the data byte changes no register. The next step is 3 if fourth-word is set, otherwise 0.
- R4: In init step 3, a data write sets fully-nested from bit 4 and auto-EOI from bit 1, and the step returns to 0. In step 0, a data write loads the mask.
- R5: A write to address 0 with bit 4 clear and bit 3 set is an operation word. Bit 2 set arms a poll. Bit 1 set loads read-select from bit 0. Bit 6 set loads special-mask from bit 5.
- R6: Other address-0 writes decode bits 7:5 as a command. Command values 0 and 4 load rotate-on-auto-EOI from bit 7.
- R7: Command 1 clears the in-service bit of highest priority. Priority runs upward from the rotation base and wraps from 7 to 0. Command 5 does the same and then sets the base to that line plus one, modulo 8. With no in-service bit set, neither command changes anything.
- R8: Command 3 clears the in-service bit named by bits 2:0. Command 7 clears that bit and sets the base to the line plus one. Command 6 sets the base to bits 2:0 plus one, modulo 8. Command 2 changes nothing.
- R9: While a poll is armed and a line is pending, a read returns 0x80 OR the line and raises the acknowledge for that line. The acknowledge sets the line's in-service bit. In auto-EOI mode it instead sets the base to the line plus one if rotate-on-auto-EOI is set. With no line pending, the read returns 0. Any read disarms the poll.
- R10: With no poll armed, a read of address 0 returns the in-service register when read-select is 1 and the request vector when it is 0. A read of address 1 returns the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| rdEn | input | 1 | Read strobe, one cycle per byte |
| addrSel | input | 1 | 0 = command address, 1 = data address |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid while rdEn is high |
| reqVec | input | 8 | Request vector from the arbiter |
| pendValid | input | 1 | The arbiter has a line to deliver |
| pendLine | input | 3 | Number of that line |
| ackValid | output | 1 | Poll read acknowledges pendLine |
| ackLine | output | 3 | Line being acknowledged |
| maskReg | output | 8 | Line mask |
| inService | output | 8 | In-service register |
| rotBase | output | 3 | Line that currently has top priority |
| vecBase | output | 8 | Vector base, bits 2:0 zero |
| autoEoi | output | 1 | Auto-EOI mode |
| rotOnAeoi | output | 1 | Rotate on auto-EOI |
| fullyNested | output | 1 | Special fully nested mode |
| specialMask | output | 1 | Special mask mode |
| readSel | output | 1 | Address-0 readback select |
| pollArmed | output | 1 | A poll is armed |
| cfgStep | output | 2 | Current initialization step |

## Verification
Directed sequences try the three initialization paths (single with fourth word, cascaded with fourth word, cascaded without). They show whether each optional step is taken or skipped, and whether step 2 ignores its data. Priority-driven end-of-interrupt commands run after rotating the base, so clearing the lowest-numbered bit is told apart from clearing the bit next in rotation order. A long stream of random command bytes, data bytes and reads, with random pending inputs, mixes poll reads into partly finished init sequences and into auto-EOI modes. Every output is compared after every access.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_LINES = 8;
  localparam int LINE_W = $clog2(NUM_LINES);

  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_VEC  = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } stepT;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic initGo;
    logic ldMask;
    logic ldVec;
    logic ldMode;
    logic armPoll;
    logic ldReadSel;
    logic ldSpecMask;
    logic ldRotAeoi;
    logic eoiHigh;
    logic eoiHighRot;
    logic eoiNamed;
    logic eoiNamedRot;
    logic setBase;
  } strobeT;
endpackage

// File: rtl/icd_ctrl.sv
module icd_ctrl
  import icd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          addrSel,
  input  logic [DW-1:0] wrData,
  output strobeT        strb,
  output logic [1:0]    cfgStep
);
  stepT stepQ, stepD;
  logic fourQ, singleQ;

  always_comb begin
    strb  = '0;
    stepD = stepQ;
    if (wrEn) begin
      if (!addrSel) begin
        if (wrData[4]) begin
          strb.initGo = 1'b1;
          stepD = STEP_VEC;
        end else if (wrData[3]) begin
          strb.armPoll    = wrData[2];
          strb.ldReadSel  = wrData[1];
          strb.ldSpecMask = wrData[6];
        end else begin
          unique case (wrData[7:5])
            3'd0, 3'd4: strb.ldRotAeoi   = 1'b1;
            3'd1:       strb.eoiHigh     = 1'b1;
            3'd5:       strb.eoiHighRot  = 1'b1;
            3'd3:       strb.eoiNamed    = 1'b1;
            3'd7:       strb.eoiNamedRot = 1'b1;
            3'd6:       strb.setBase     = 1'b1;
            default:    ;
          endcase
        end
      end else begin
        unique case (stepQ)
          STEP_RUN: strb.ldMask = 1'b1;
          STEP_VEC: begin
            strb.ldVec = 1'b1;
            stepD = singleQ ? (fourQ ? STEP_MODE : STEP_RUN) : STEP_CASC;
          end
          STEP_CASC: stepD = fourQ ? STEP_MODE : STEP_RUN;
          STEP_MODE: begin
            strb.ldMode = 1'b1;
            stepD = STEP_RUN;
          end
          default: stepD = STEP_RUN;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ   <= STEP_RUN;
      fourQ   <= 1'b0;
      singleQ <= 1'b0;
    end else begin
      stepQ <= stepD;
      if (strb.initGo) begin
        fourQ   <= wrData[0];
        singleQ <= wrData[1];
      end
    end
  end

  assign cfgStep = stepQ;

  // R4
  mode_step_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrSel && stepQ == STEP_MODE) |=> (stepQ == STEP_RUN));

  // R2
  vec_step_cascade_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrSel && stepQ == STEP_VEC && !singleQ) |=> (stepQ == STEP_CASC));

  // R1
  init_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrSel && wrData[4]) |=> (stepQ == STEP_VEC));
endmodule

// File: rtl/icd_dpath.sv
module icd_dpath
  import icd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NL = NUM_LINES,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic          addrSel,
  output logic [DW-1:0] rdData,
  input  logic [NL-1:0] reqVec,
  input  logic          pendValid,
  input  logic [LW-1:0] pendLine,
  output logic          ackValid,
  output logic [LW-1:0] ackLine,
  output logic [NL-1:0] maskReg,
  output logic [NL-1:0] inService,
  output logic [LW-1:0] rotBase,
  output logic [DW-1:0] vecBase,
  output logic          autoEoi,
  output logic          rotOnAeoi,
  output logic          fullyNested,
  output logic          specialMask,
  output logic          readSel,
  output logic          pollArmed
);
  localparam logic [DW-1:0] VEC_KEEP = ~DW'(NL - 1);
  localparam logic [DW-1:0] POLL_HIT = DW'(1) << (DW - 1);

  logic          hiFound;
  logic [LW-1:0] hiLine;
  logic [LW-1:0] scanIdx;
  logic [LW-1:0] namedLine;
  logic          pollRead;

  // highest-priority in-service line, scanning upward from rotBase
  always_comb begin
    hiFound = 1'b0;
    hiLine  = '0;
    scanIdx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      scanIdx = rotBase + LW'(i);
      if (inService[scanIdx]) begin
        hiFound = 1'b1;
        hiLine  = scanIdx;
      end
    end
  end

  assign namedLine = wrData[LW-1:0];
  assign pollRead  = rdEn && pollArmed;
  assign ackValid  = pollRead && pendValid;
  assign ackLine   = pendLine;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (pollArmed)
        rdData = pendValid ? (POLL_HIT | DW'(pendLine)) : '0;
      else if (addrSel)
        rdData = DW'(maskReg);
      else
        rdData = readSel ? DW'(inService) : DW'(reqVec);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg     <= '0;
      inService   <= '0;
      rotBase     <= '0;
      vecBase     <= '0;
      autoEoi     <= 1'b0;
      rotOnAeoi   <= 1'b0;
      fullyNested <= 1'b0;
      specialMask <= 1'b0;
      readSel     <= 1'b0;
      pollArmed   <= 1'b0;
    end else begin
      if (pollRead) pollArmed <= 1'b0;
      if (ackValid) begin
        if (autoEoi) begin
          if (rotOnAeoi) rotBase <= pendLine + LW'(1);
        end else begin
          inService[pendLine] <= 1'b1;
        end
      end
      if (strb.initGo) begin
        maskReg     <= '0;
        inService   <= '0;
        rotBase     <= '0;
        autoEoi     <= 1'b0;
        rotOnAeoi   <= 1'b0;
        specialMask <= 1'b0;
        readSel     <= 1'b0;
        pollArmed   <= 1'b0;
      end
      if (strb.ldMask) maskReg <= NL'(wrData);
      if (strb.ldVec) vecBase <= wrData & VEC_KEEP;
      if (strb.ldMode) begin
        fullyNested <= wrData[4];
        autoEoi     <= wrData[1];
      end
      if (strb.armPoll) pollArmed <= 1'b1;
      if (strb.ldReadSel) readSel <= wrData[0];
      if (strb.ldSpecMask) specialMask <= wrData[5];
      if (strb.ldRotAeoi) rotOnAeoi <= wrData[7];
      if ((strb.eoiHigh || strb.eoiHighRot) && hiFound) begin
        inService[hiLine] <= 1'b0;
        if (strb.eoiHighRot) rotBase <= hiLine + LW'(1);
      end
      if (strb.eoiNamed || strb.eoiNamedRot) inService[namedLine] <= 1'b0;
      if (strb.eoiNamedRot || strb.setBase) rotBase <= namedLine + LW'(1);
    end
  end

  // R8
  set_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setBase && !rdEn) |=> (rotBase == $past(namedLine) + LW'(1)));

  // R9
  poll_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !strb.armPoll) |=> !pollArmed);

  // R9
  ack_marks_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !autoEoi && !strb.initGo) |=> inService[$past(ackLine)]);

  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.initGo && !rdEn) |=> (maskReg == '0 && inService == '0 && rotBase == '0));

  // R5
  read_sel_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldReadSel |=> (readSel == $past(wrData[0])));

  // R7
  eoi_none_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.eoiHigh || strb.eoiHighRot) && inService == '0 && !rdEn)
      |=> ($stable(inService) && $stable(rotBase)));
endmodule

// File: rtl/icd_top.sv
module icd_top
  import icd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NL = NUM_LINES,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          addrSel,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic [NL-1:0] reqVec,
  input  logic          pendValid,
  input  logic [LW-1:0] pendLine,
  output logic          ackValid,
  output logic [LW-1:0] ackLine,
  output logic [NL-1:0] maskReg,
  output logic [NL-1:0] inService,
  output logic [LW-1:0] rotBase,
  output logic [DW-1:0] vecBase,
  output logic          autoEoi,
  output logic          rotOnAeoi,
  output logic          fullyNested,
  output logic          specialMask,
  output logic          readSel,
  output logic          pollArmed,
  output logic [1:0]    cfgStep
);
  strobeT strb;

  icd_ctrl #(.DW(DW)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addrSel (addrSel),
    .wrData  (wrData),
    .strb    (strb),
    .cfgStep (cfgStep)
  );

  icd_dpath #(.DW(DW), .NL(NL)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .rdEn        (rdEn),
    .addrSel     (addrSel),
    .rdData      (rdData),
    .reqVec      (reqVec),
    .pendValid   (pendValid),
    .pendLine    (pendLine),
    .ackValid    (ackValid),
    .ackLine     (ackLine),
    .maskReg     (maskReg),
    .inService   (inService),
    .rotBase     (rotBase),
    .vecBase     (vecBase),
    .autoEoi     (autoEoi),
    .rotOnAeoi   (rotOnAeoi),
    .fullyNested (fullyNested),
    .specialMask (specialMask),
    .readSel     (readSel),
    .pollArmed   (pollArmed)
  );
endmodule

// File: tb/icd_top_tb_top.sv
`timescale 1ns/1ps
module icd_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, addrSel = 1'b0;
  logic [7:0] wrData = '0, reqVec = '0;
  logic       pendValid = 1'b0;
  logic [2:0] pendLine = '0;
  logic [7:0] rdData, maskReg, inService, vecBase;
  logic       ackValid, autoEoi, rotOnAeoi, fullyNested, specialMask, readSel, pollArmed;
  logic [2:0] ackLine, rotBase;
  logic [1:0] cfgStep;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // expected model
  logic [7:0] eMask, eIsr, eVec;
  logic [2:0] eRot;
  logic [1:0] eStep;
  logic eAe, eRae, eFnm, eSm, eRs, ePoll, eFour, eSingle;

  always #2.5 clk = ~clk;

  icd_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addrSel(addrSel),
    .wrData(wrData), .rdData(rdData), .reqVec(reqVec), .pendValid(pendValid),
    .pendLine(pendLine), .ackValid(ackValid), .ackLine(ackLine),
    .maskReg(maskReg), .inService(inService), .rotBase(rotBase),
    .vecBase(vecBase), .autoEoi(autoEoi), .rotOnAeoi(rotOnAeoi),
    .fullyNested(fullyNested), .specialMask(specialMask), .readSel(readSel),
    .pollArmed(pollArmed), .cfgStep(cfgStep)
  );

  function automatic int hiIsr(logic [7:0] isr, logic [2:0] base);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] idx = base + 3'(i);
      if (isr[idx]) return int'(idx);
    end
    return -1;
  endfunction

  function automatic string tagFor(logic a, logic [7:0] d, logic [1:0] st);
    if (a) return (st == 2'd0 || st == 2'd3) ? "R4" : (st == 2'd1) ? "R2" : "R3";
    if (d[4]) return "R1";
    if (d[3]) return "R5";
    case (d[7:5])
      3'd0, 3'd4: return "R6";
      3'd1, 3'd5: return "R7";
      default:    return "R8";
    endcase
  endfunction

  function automatic logic [38:0] expState();
    return {eMask, eIsr, eRot, eVec, eAe, eRae, eFnm, eSm, eRs, ePoll, eStep};
  endfunction

  function automatic logic [38:0] actState();
    return {maskReg, inService, rotBase, vecBase, autoEoi, rotOnAeoi,
            fullyNested, specialMask, readSel, pollArmed, cfgStep};
  endfunction

  task automatic check(string tag, logic [38:0] act, logic [38:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    eMask = '0; eIsr = '0; eRot = '0; eVec = '0; eAe = 0; eRae = 0; eFnm = 0;
    eSm = 0; eRs = 0; ePoll = 0; eStep = 0; eFour = 0; eSingle = 0;
  endtask

  task automatic modelWrite(logic a, logic [7:0] d);
    int h;
    if (!a) begin
      if (d[4]) begin
        eMask = '0; eIsr = '0; eRot = '0; ePoll = 0; eRs = 0; eSm = 0; eAe = 0; eRae = 0;
        eStep = 2'd1; eFour = d[0]; eSingle = d[1];
      end else if (d[3]) begin
        if (d[2]) ePoll = 1;
        if (d[1]) eRs = d[0];
        if (d[6]) eSm = d[5];
      end else begin
        case (d[7:5])
          3'd0, 3'd4: eRae = d[7];
          3'd1, 3'd5: begin
            h = hiIsr(eIsr, eRot);
            if (h >= 0) begin
              eIsr[h] = 1'b0;
              if (d[7]) eRot = 3'(h + 1);
            end
          end
          3'd3: eIsr[d[2:0]] = 1'b0;
          3'd6: eRot = d[2:0] + 3'd1;
          3'd7: begin eIsr[d[2:0]] = 1'b0; eRot = d[2:0] + 3'd1; end
          default: ;
        endcase
      end
    end else begin
      case (eStep)
        2'd0: eMask = d;
        2'd1: begin eVec = d & 8'hF8; eStep = eSingle ? (eFour ? 2'd3 : 2'd0) : 2'd2; end
        2'd2: eStep = eFour ? 2'd3 : 2'd0;
        default: begin eFnm = d[4]; eAe = d[1]; eStep = 2'd0; end
      endcase
    end
  endtask

  task automatic doWrite(logic a, logic [7:0] d);
    string tag;
    @(negedge clk);
    tag = tagFor(a, d, eStep);
    wrEn = 1; addrSel = a; wrData = d;
    pendValid = 1'($urandom); pendLine = 3'($urandom); reqVec = 8'($urandom);
    modelWrite(a, d);
    @(posedge clk);
    @(negedge clk);
    wrEn = 0;
    check(tag, actState(), expState());
  endtask

  task automatic doRead(logic a, logic pv, logic [2:0] pl, logic [7:0] rq);
    logic [7:0] expRd;
    logic expAck;
    string tag;
    @(negedge clk);
    rdEn = 1; addrSel = a; pendValid = pv; pendLine = pl; reqVec = rq;
    expAck = 0;
    if (ePoll) begin
      tag = "R9";
      if (pv) begin
        expRd = 8'h80 | {5'd0, pl};
        expAck = 1;
        if (eAe) begin
          if (eRae) eRot = pl + 3'd1;
        end else eIsr[pl] = 1'b1;
      end else expRd = 8'h00;
      ePoll = 0;
    end else begin
      tag = "R10";
      expRd = a ? eMask : (eRs ? eIsr : rq);
    end
    #1;
    check(tag, {31'd0, rdData}, {31'd0, expRd});
    check(tag, {35'd0, ackValid, expAck ? ackLine : 3'd0}, {35'd0, expAck, expAck ? pl : 3'd0});
    @(posedge clk);
    @(negedge clk);
    rdEn = 0;
    check(tag, actState(), expState());
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check("R1", actState(), expState());

    // R2 R4: single mode with fourth word
    doWrite(0, 8'h13);
    doWrite(1, 8'h47);
    doWrite(1, 8'h12);
    // R3: cascade with fourth word, step 2 ignores data
    doWrite(0, 8'h11);
    doWrite(1, 8'h28);
    doWrite(1, 8'hFF);
    doWrite(1, 8'h00);
    // R2 R3: cascade without fourth word, then mask
    doWrite(0, 8'h10);
    doWrite(1, 8'h9B);
    doWrite(1, 8'h55);
    doWrite(1, 8'hA5);
    doRead(1, 0, 0, 8'h00);

    // R9: polls load in-service bits
    doWrite(0, 8'h0C);
    doRead(0, 1, 3'd5, 8'h11);
    doWrite(0, 8'h0C);
    doRead(1, 1, 3'd2, 8'h22);
    doWrite(0, 8'h0C);
    doRead(0, 0, 3'd6, 8'h33);
    // R8: base to 4, R7: priority clears 5 then 2 with rotation
    doWrite(0, 8'hC3);
    doWrite(0, 8'h20);
    doWrite(0, 8'h0C);
    doRead(0, 1, 3'd0, 8'h00);
    doWrite(0, 8'hA0);
    doWrite(0, 8'hA0);
    doWrite(0, 8'h20);
    // R8: command 2 no-op, command 7, command 3
    doWrite(0, 8'h0C);
    doRead(0, 1, 3'd6, 8'h00);
    doWrite(0, 8'h40);
    doWrite(0, 8'hE6);
    doWrite(0, 8'h0C);
    doRead(0, 1, 3'd1, 8'h00);
    doWrite(0, 8'h61);
    // R5 R10: read-select and special mask
    doWrite(0, 8'h6B);
    doRead(0, 0, 0, 8'h5A);
    doWrite(0, 8'h4A);
    doRead(0, 0, 0, 8'h5A);
    // R6 R9: auto-EOI with rotation
    doWrite(0, 8'h13);
    doWrite(1, 8'h20);
    doWrite(1, 8'h02);
    doWrite(0, 8'h80);
    doWrite(0, 8'h0C);
    doRead(0, 1, 3'd6, 8'h00);
    doWrite(0, 8'h00);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      d = 8'($urandom);
      if (r <= 3) begin
        if (d[4] && ($urandom_range(0, 3) != 0)) d[4] = 1'b0;
        doWrite(0, d);
      end else if (r <= 5) begin
        doWrite(1, d);
      end else begin
        doRead(1'($urandom), 1'($urandom), 3'($urandom), 8'($urandom));
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule